// File: doc/BRIEF.md
# Frame DMA Burst Fetcher

This block keeps a local pixel FIFO filled with one display frame that it reads from memory. Software gives it a base address, a frame length in 32-bit words (horizontal resolution × vertical resolution × bits per pixel / 32) and a FIFO fill threshold, then sets the enable bit. From then on the block issues fixed 8-word read bursts on a simple request/response port. Each burst takes the next consecutive addresses, and the fetch wraps back to the base address once the frame is complete. The display side pops one word at a time.

A new burst starts only when no burst is outstanding and the FIFO occupancy is at or below the threshold. With the default threshold of 493, a burst of 8 words always fits. The block raises sticky error flags when the display pops from an empty FIFO, when a response arrives into a full FIFO (the word is lost), and when the memory signals an error. Each flag has its own interrupt enable.

Top module: `frame_fetch_dma`

## Requirements
- R1: After reset no request is raised, irq is low, and the following registers read as shown: index 0 (enable, bit 0) reads 0, index 3 (threshold) reads 493 = 512 − (2×8 + 3), index 6 (flags) reads 0 and index 7 (status) reads 0. cfg_rdata shows the register that cfg_addr selected one cycle earlier.
- R2: A burst request is raised only under three conditions: enable (index 0 bit 0) is 1, no burst is outstanding, and FIFO occupancy is at or below the threshold (index 3). Its address is the base (index 1, with bits 1:0 forced to 0) plus 4 × the current word offset. The request stays high with a stable address until mem_req_ready accepts it.
- R3: Only one burst is outstanding at a time: after a request is accepted, no new request appears until 8 responses have arrived.
- R4: The word offset advances by 8 at each accepted burst. When the advanced offset reaches or passes the frame length (index 2, in 32-bit words), the next burst starts at offset 0.
- R5: Response words enter the 512-word FIFO in arrival order. A pop presents the oldest word on disp_data one cycle later. Status (index 7) bits 25:16 hold the occupancy and bit 0 holds busy.
- R6: A pop while the FIFO is empty sets flag bit 0 (underflow) and leaves the occupancy unchanged.
- R7: A response that arrives while the FIFO holds 512 words is dropped and sets flag bit 1 (overwrite). Occupancy never exceeds 512.
- R8: A response with mem_rsp_err high sets flag bit 2 (memory error).
- R9: Flags stay set until 1 is written to their bit at index 6. Writing 1s at index 4 sets interrupt-enable bits and writing 1s at index 5 clears them; index 4 reads back the enable mask. irq is high one cycle after any flag has its enable bit set, and low otherwise.
- R10: Clearing enable blocks new requests, but a burst already accepted still completes. Busy (status bit 0) stays 1 until that burst's 8th response.
- R11: Every 0→1 change of enable restarts the fetch at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the index selected one cycle earlier |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_addr | output | AW | Byte address of the first burst word |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | One response word valid |
| mem_rsp_data | input | 32 | Response word |
| mem_rsp_err | input | 1 | Response carries a memory error |
| disp_pop | input | 1 | Display side removes one word |
| disp_data | output | 32 | Popped word, valid the cycle after the pop |
| irq | output | 1 | Any enabled sticky flag is set |

## Verification
The properties assume that the memory returns exactly 8 responses for each accepted request and returns none otherwise. The properties also assume that mem_req_ready is never needed to withdraw a request. The bench's memory model enforces both. It answers each accepted request with 8 consecutive words whose value equals their byte address. It can hold those responses back, or mark the first one as an error, without ever adding or dropping a response. The display side pops only while no burst is in flight, so the bench's FIFO model needs no ordering between a push and a pop on the same edge.

// File: rtl/frame_fetch_pkg.sv
package frame_fetch_pkg;
  typedef enum logic [1:0] {BS_IDLE, BS_REQ, BS_RESP} burst_state_e;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_BASE   = 3'd1;
  localparam logic [2:0] RA_FRAME  = 3'd2;
  localparam logic [2:0] RA_THRESH = 3'd3;
  localparam logic [2:0] RA_IEN_SET = 3'd4;
  localparam logic [2:0] RA_IEN_CLR = 3'd5;
  localparam logic [2:0] RA_FLAGS  = 3'd6;
  localparam logic [2:0] RA_STATUS = 3'd7;

  localparam int unsigned NFLAG = 3;
  localparam int unsigned FLG_UNDER = 0;
  localparam int unsigned FLG_OVER  = 1;
  localparam int unsigned FLG_MERR  = 2;
  localparam int unsigned OCC_LSB   = 16;
endpackage

// File: rtl/frame_fetch_fifo.sv
module frame_fetch_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] occ,
  output logic          ev_underflow,
  output logic          ev_overwrite
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (occ == CW'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push_valid && !full;
  assign do_pop  = pop_req && !empty;

  assign ev_underflow = pop_req && empty;
  assign ev_overwrite = push_valid && full;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) pop_data <= store[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(1);
      if (do_pop)  rp <= rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/frame_fetch_burst.sv
module frame_fetch_burst
  import frame_fetch_pkg::*;
#(
  parameter int AW   = 32,
  parameter int FW   = 24,
  parameter int CW   = 10,
  parameter int BLEN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic [AW-1:0] base,
  input  logic [FW-1:0] frame_words,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] occ,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic          busy
);
  localparam int BCW = (BLEN > 1) ? $clog2(BLEN) : 1;
  localparam logic [BCW-1:0] RLAST = BCW'(BLEN - 1);
  localparam logic [FW:0]    BSTEP = (FW+1)'(BLEN);

  burst_state_e  state;
  logic [FW-1:0] wcnt;
  logic [BCW-1:0] rcnt;
  logic          en_q;
  logic          restart, room_ok;
  logic [FW-1:0] cur_w;
  logic [FW:0]   wnext;

  assign restart = dma_en && !en_q;
  assign room_ok = dma_en && (occ <= thr);
  assign cur_w   = restart ? '0 : wcnt;
  assign wnext   = {1'b0, wcnt} + BSTEP;
  assign busy    = (state != BS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= BS_IDLE;
      wcnt          <= '0;
      rcnt          <= '0;
      en_q          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      en_q <= dma_en;
      case (state)
        BS_IDLE: begin
          if (room_ok) begin
            state         <= BS_REQ;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= base + AW'({cur_w, 2'b00});
          end
        end
        BS_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= BS_RESP;
            rcnt          <= '0;
            wcnt          <= (wnext >= {1'b0, frame_words}) ? '0 : wnext[FW-1:0];
          end
        end
        BS_RESP: begin
          if (mem_rsp_valid) begin
            if (rcnt == RLAST) state <= BS_IDLE;
            else               rcnt  <= rcnt + BCW'(1);
          end
        end
        default: state <= BS_IDLE;
      endcase
      if (restart) wcnt <= '0;
    end
  end
endmodule

// File: rtl/frame_fetch_regs.sv
module frame_fetch_regs
  import frame_fetch_pkg::*;
#(
  parameter int AW        = 32,
  parameter int FW        = 24,
  parameter int CW        = 10,
  parameter int THR_RESET = 493
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             dma_en,
  output logic [AW-1:0]    base,
  output logic [FW-1:0]    frame_words,
  output logic [CW-1:0]    thr,
  output logic [NFLAG-1:0] flags,
  input  logic             ev_underflow,
  input  logic             ev_overwrite,
  input  logic             ev_memerr,
  input  logic             busy,
  input  logic [CW-1:0]    occ,
  output logic             irq
);
  logic [NFLAG-1:0] ien;
  logic [NFLAG-1:0] ev_vec;
  logic [NFLAG-1:0] flags_n;
  logic [31:0]      rd_v;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    ev_vec = '0;
    ev_vec[FLG_UNDER] = ev_underflow;
    ev_vec[FLG_OVER]  = ev_overwrite;
    ev_vec[FLG_MERR]  = ev_memerr;
    flags_n = flags;
    if (we && addr == RA_FLAGS) flags_n = flags_n & ~wdata[NFLAG-1:0];
    flags_n = flags_n | ev_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_en      <= 1'b0;
      base        <= '0;
      frame_words <= '0;
      thr         <= CW'(THR_RESET);
      ien         <= '0;
      flags       <= '0;
      irq         <= 1'b0;
    end else begin
      flags <= flags_n;
      irq   <= |(flags & ien);
      if (we) begin
        case (addr)
          RA_CTRL:    dma_en      <= wdata[0];
          RA_BASE:    base        <= {wdata[AW-1:2], 2'b00};
          RA_FRAME:   frame_words <= wdata[FW-1:0];
          RA_THRESH:  thr         <= wdata[CW-1:0];
          RA_IEN_SET: ien         <= ien | wdata[NFLAG-1:0];
          RA_IEN_CLR: ien         <= ien & ~wdata[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_v = '0;
    case (addr)
      RA_CTRL:    rd_v[0] = dma_en;
      RA_BASE:    rd_v = 32'(base);
      RA_FRAME:   rd_v = 32'(frame_words);
      RA_THRESH:  rd_v = 32'(thr);
      RA_IEN_SET,
      RA_IEN_CLR: rd_v = 32'(ien);
      RA_FLAGS:   rd_v = 32'(flags);
      RA_STATUS: begin
        rd_v[OCC_LSB +: CW] = occ;
        rd_v[0]             = busy;
      end
      default: rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_v;
  end
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma
  import frame_fetch_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int BLEN  = 8,
  parameter int AW    = 32,
  parameter int FW    = 24,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  input  logic          disp_pop,
  output logic [DW-1:0] disp_data,
  output logic          irq
);
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int THR_RESET = DEPTH - (2 * BLEN + 3);

  logic             dma_en, busy;
  logic [AW-1:0]    base;
  logic [FW-1:0]    frame_words;
  logic [CW-1:0]    thr, occ;
  logic [NFLAG-1:0] irq_flags;
  logic             ev_underflow, ev_overwrite, ev_memerr;

  assign ev_memerr = mem_rsp_valid && mem_rsp_err;

  frame_fetch_regs #(
    .AW(AW), .FW(FW), .CW(CW), .THR_RESET(THR_RESET)
  ) u_regs (
    .clk(clk), .rst(rst),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .dma_en(dma_en), .base(base), .frame_words(frame_words), .thr(thr),
    .flags(irq_flags),
    .ev_underflow(ev_underflow), .ev_overwrite(ev_overwrite), .ev_memerr(ev_memerr),
    .busy(busy), .occ(occ), .irq(irq)
  );

  frame_fetch_burst #(
    .AW(AW), .FW(FW), .CW(CW), .BLEN(BLEN)
  ) u_burst (
    .clk(clk), .rst(rst),
    .dma_en(dma_en), .base(base), .frame_words(frame_words),
    .thr(thr), .occ(occ),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .busy(busy)
  );

  frame_fetch_fifo #(
    .DW(DW), .DEPTH(DEPTH), .CW(CW)
  ) u_fifo (
    .clk(clk), .rst(rst),
    .push_valid(mem_rsp_valid), .push_data(mem_rsp_data),
    .pop_req(disp_pop), .pop_data(disp_data),
    .occ(occ),
    .ev_underflow(ev_underflow), .ev_overwrite(ev_overwrite)
  );
endmodule

// File: rtl/frame_fetch_dma_chk.sv
module frame_fetch_dma_chk #(
  parameter int DEPTH = 512,
  parameter int BLEN  = 8,
  parameter int AW    = 32,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_err,
  input logic          disp_pop,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] thr,
  input logic          dma_en,
  input logic [2:0]    flags
);
  localparam int OC = $clog2(BLEN + 1);

  logic [OC-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else if (mem_req_valid && mem_req_ready) pend <= OC'(BLEN);
    else if (mem_rsp_valid && pend != '0) pend <= pend - OC'(1);
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(dma_en) && ($past(occ) <= $past(thr))); // R2
  AST_ONE_BURST: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> pend == '0); // R3
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    disp_pop && occ == '0 |=> flags[0]); // R6
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH)); // R7
  AST_OVERWRITE_FLAG: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && occ == CW'(DEPTH) |=> flags[1]); // R7
  AST_DROP_KEEPS_OCC: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && occ == CW'(DEPTH) && !disp_pop |=> occ == CW'(DEPTH)); // R7
  AST_MEMERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && mem_rsp_err |=> flags[2]); // R8
endmodule

bind frame_fetch_dma frame_fetch_dma_chk #(
  .DEPTH(DEPTH), .BLEN(BLEN), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
  .disp_pop(disp_pop), .occ(occ), .thr(thr), .dma_en(dma_en),
  .flags(irq_flags)
);

// File: tb/frame_fetch_dma_test.sv
module frame_fetch_dma_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        disp_pop = 1'b0;
  logic [31:0] disp_data;
  logic        irq;

  int nchk = 0;
  int nfail = 0;

  // memory model state
  int          pend = 0;
  logic [31:0] cur = '0;
  bit          rsp_hold = 1'b0;
  bit          err_next = 1'b0;
  int          req_n = 0;
  int          r3_bad = 0;
  logic [31:0] req_log [64];

  // FIFO model
  logic [31:0] m_q [512];
  int m_wp = 0, m_rp = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_fetch_dma uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .disp_pop(disp_pop), .disp_data(disp_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic pop_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] e;
      @(negedge clk);
      disp_pop = 1'b1;
      @(negedge clk);
      disp_pop = 1'b0;
      e = m_q[m_rp];
      m_rp = (m_rp + 1) % 512;
      m_cnt--;
      chk(tag, disp_data, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory responder: 8 words per accepted request, data equals byte address
  initial begin
    forever begin
      @(negedge clk);
      if (pend > 0 && !rsp_hold) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = cur;
        mem_rsp_err   = err_next;
        err_next      = 1'b0;
        if (m_cnt < 512) begin
          m_q[m_wp] = cur;
          m_wp = (m_wp + 1) % 512;
          m_cnt++;
        end
        cur  = cur + 32'd4;
        pend--;
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (pend != 0) r3_bad++;
        req_log[req_n % 64] = mem_req_addr;
        req_n++;
        pend = 8;
        cur  = mem_req_addr;
      end
    end
  end

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 req", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd3, v); chk("R1 threshold", v, 32'd493);
    rd(3'd6, v); chk("R1 flags", v, 32'd0);
    rd(3'd7, v); chk("R1 status", v, 32'd0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(3'd1, 32'h0000_1003);
    wr(3'd2, 32'd24);
    rd(3'd1, v); chk("R2 base aligned", v, 32'h0000_1000);
    idle(20);
    chk("R2 no request while disabled", 32'(req_n), 32'd0);
  endtask

  task automatic t_fetch_wrap;
    logic [31:0] v;
    wr(3'd0, 32'd1);
    while (req_n < 5) @(negedge clk);
    wr(3'd0, 32'd0);
    idle(30);
    chk("R2 burst count", 32'(req_n), 32'd5);
    chk("R2 addr0", req_log[0], 32'h1000);
    chk("R4 addr1", req_log[1], 32'h1020);
    chk("R4 addr2", req_log[2], 32'h1040);
    chk("R4 wrap addr3", req_log[3], 32'h1000);
    chk("R4 addr4", req_log[4], 32'h1020);
    chk("R3 one burst outstanding", 32'(r3_bad), 32'd0);
    rd(3'd7, v); chk("R5 occupancy", v, 32'h0028_0000);
  endtask

  task automatic t_order_underflow;
    logic [31:0] v;
    pop_check(40, "R5 order");
    rd(3'd7, v); chk("R5 empty", v, 32'd0);
    wr(3'd4, 32'd1);
    @(negedge clk); disp_pop = 1'b1;
    @(negedge clk); disp_pop = 1'b0;
    idle(2);
    rd(3'd6, v); chk("R6 underflow flag", v, 32'd1);
    rd(3'd7, v); chk("R6 occupancy unchanged", v, 32'd0);
    chk("R9 irq on enabled flag", {31'b0, irq}, 32'd1);
    wr(3'd6, 32'd1);
    rd(3'd6, v); chk("R9 flag cleared", v, 32'd0);
    @(negedge clk);
    chk("R9 irq released", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_threshold_restart;
    logic [31:0] v;
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'd1024);
    wr(3'd3, 32'd16);
    wr(3'd0, 32'd1);
    idle(80);
    chk("R2 threshold stops bursts", 32'(req_n), 32'd8);
    chk("R11 restart at base", req_log[5], 32'h2000);
    chk("R4 next offset", req_log[6], 32'h2020);
    rd(3'd7, v); chk("R2 occupancy at threshold stop", v, 32'h0018_0000);
    wr(3'd0, 32'd0);
    idle(4);
    pop_check(24, "R5 order after restart");
  endtask

  task automatic t_busy_memerr;
    logic [31:0] v;
    rsp_hold = 1'b1;
    err_next = 1'b1;
    wr(3'd0, 32'd1);
    while (req_n < 9) @(negedge clk);
    idle(3);
    wr(3'd0, 32'd0);
    idle(10);
    chk("R10 no request after disable", {31'b0, mem_req_valid}, 32'd0);
    rd(3'd7, v); chk("R10 busy while in flight", v, 32'd1);
    rsp_hold = 1'b0;
    idle(20);
    rd(3'd7, v); chk("R10 burst completed", v, 32'h0008_0000);
    chk("R10 no further bursts", 32'(req_n), 32'd9);
    chk("R11 restart after re-enable", req_log[8], 32'h2000);
    rd(3'd6, v); chk("R8 memory error flag", v, 32'd4);
    chk("R9 masked flag keeps irq low", {31'b0, irq}, 32'd0);
    wr(3'd4, 32'd4);
    idle(2);
    chk("R9 enable set raises irq", {31'b0, irq}, 32'd1);
    wr(3'd5, 32'd4);
    idle(2);
    chk("R9 enable clear drops irq", {31'b0, irq}, 32'd0);
    rd(3'd4, v); chk("R9 enable mask", v, 32'd1);
    rd(3'd6, v); chk("R9 flag stays sticky", v, 32'd4);
    wr(3'd6, 32'd4);
  endtask

  task automatic t_overwrite;
    logic [31:0] v;
    wr(3'd3, 32'd512);
    wr(3'd0, 32'd1);
    while (req_n < 76) @(negedge clk);
    wr(3'd0, 32'd0);
    idle(30);
    rd(3'd7, v); chk("R7 occupancy capped", v, 32'h0200_0000);
    rd(3'd6, v); chk("R7 overwrite flag", v, 32'd2);
    pop_check(512, "R7 dropped words absent");
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fetch_wrap();
    t_order_underflow();
    t_threshold_restart();
    t_busy_memerr();
    t_overwrite();
    report();
  end
endmodule